// File: doc/BRIEF.md
# Privilege Level and Access Checker

This block is a purely combinational screen that sits beside an instruction pipeline's memory and system-register paths. From a handful of processor status bits it derives the privilege level the core is running at. It then answers three questions about the current operation: may a system-control (coprocessor-0) register be touched, does a data access of the given size stay inside one 16-byte block, and does the current level meet a level that the caller names.

The block keeps no state and has no clock. Every output follows its inputs within the same cycle. Raising the resulting exception and translating the address belong to neighbouring logic. The access request is a plain qualifier rather than a handshake. The block never stalls anything, so it has no back-pressure rules: `acc_valid` only gates the alignment result.

Top module: `priv_access_check`

## Requirements
- R1: When `st_exl` or `st_erl` is 1, `eff_level` is 2 (kernel), whatever `st_ksu` holds.
- R2: With `st_exl` and `st_erl` both 0, `st_ksu` selects the level: 00 gives 2 (kernel), 01 gives 1 (supervisor), 10 gives 0 (user), and the undefined 11 gives 0 (user).
- R3: `grant` is 1 exactly when `eff_level` is numerically greater than or equal to `need_level`. Levels are user 0, supervisor 1, kernel 2, so a `need_level` of 3 is never granted.
- R4: `cpu_fault` is 1 exactly when `cp0_req` is 1, `eff_level` is not kernel and `st_cu0` is 0.
- R5: `cpu_ce` is always 00. This is the coprocessor number a neighbour records with the unusable fault.
- R6: The `acc_size` code gives the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R7: With `acc_valid` at 1, `align_fault` is 1 exactly when floor(addr/16) differs from floor((addr+bytes-1)/16), with the sum taken without wrap. For example, addr 0x0E with 4 bytes faults, and addr 0x08 with 8 bytes does not.
- R8: `align_fault` is 0 whenever `acc_valid` is 0, for any address and size.
- R9: A coprocessor-0 request raises no fault at kernel level, nor when `st_cu0` is 1 at any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_exl | input | 1 | Status exception-level bit |
| st_erl | input | 1 | Status error-level bit |
| st_ksu | input | 2 | Status mode field |
| st_cu0 | input | 1 | Coprocessor-0 usable bit |
| cp0_req | input | 1 | Current operation touches a coprocessor-0 register |
| acc_valid | input | 1 | A data access is requested |
| acc_addr | input | 64 | Data address |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| need_level | input | 2 | Level required by the caller |
| eff_level | output | 2 | Effective level: 0 user, 1 supervisor, 2 kernel |
| cpu_fault | output | 1 | Coprocessor-unusable fault |
| cpu_ce | output | 2 | Coprocessor number reported with the fault |
| grant | output | 1 | Current level meets `need_level` |
| align_fault | output | 1 | Access crosses a 16-byte block |

## Verification
The in-line checks assume that every input is a known 0 or 1 and settles before it is sampled. They assume nothing about which input combinations can occur. The stimulus therefore walks every combination of the status bits, the request bit and the required level. It also sweeps the address offsets across two 16-byte blocks at every size, with the valid bit both high and low. This includes a base near the top of the 64-bit space, where the end of the access carries past the address width.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;
  localparam int LVL_W  = 2;
  localparam int SIZE_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER   = 2'd0,
    LVL_SUPER  = 2'd1,
    LVL_KERNEL = 2'd2
  } priv_lvl_e;
endpackage

// File: rtl/priv_level_decode.sv
module priv_level_decode
  import priv_chk_pkg::*;
(
  input  logic       exl,
  input  logic       erl,
  input  logic [1:0] ksu,
  output priv_lvl_e  lvl
);
  always_comb begin
    if (exl || erl) begin
      lvl = LVL_KERNEL;
    end else begin
      unique case (ksu)
        2'b00:   lvl = LVL_KERNEL;
        2'b01:   lvl = LVL_SUPER;
        default: lvl = LVL_USER;   // 10 and the undefined 11
      endcase
    end
  end

  always_comb begin
    if (ksu == 2'b11 && !exl && !erl)
      p_undef_user_r2: assert (lvl == LVL_USER);
  end
endmodule

// File: rtl/cop_gate.sv
module cop_gate
  import priv_chk_pkg::*;
#(
  parameter int CE_W = 2
) (
  input  priv_lvl_e        lvl,
  input  logic             usable,
  input  logic             req,
  output logic             fault,
  output logic [CE_W-1:0]  ce
);
  assign fault = req && (lvl != LVL_KERNEL) && !usable;
  assign ce    = '0;   // the system-control coprocessor is number zero
endmodule

// File: rtl/span_check.sv
module span_check #(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 16,
  parameter int SIZE_W      = 2
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              fault
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] first_x, last_x, span_m1;

  always_comb begin
    span_m1 = ({{(EXT_W-1){1'b0}}, 1'b1} << size) - {{(EXT_W-1){1'b0}}, 1'b1};
    first_x = {1'b0, addr};
    last_x  = first_x + span_m1;
    fault   = valid && (first_x[EXT_W-1:OFF_W] != last_x[EXT_W-1:OFF_W]);
  end

  always_comb begin
    if (valid && size == '0)
      p_byte_fits_r7: assert (!fault);
  end
endmodule

// File: rtl/priv_access_check.sv
module priv_access_check
  import priv_chk_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 16
) (
  input  logic              st_exl,
  input  logic              st_erl,
  input  logic [1:0]        st_ksu,
  input  logic              st_cu0,
  input  logic              cp0_req,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [LVL_W-1:0]  need_level,
  output logic [LVL_W-1:0]  eff_level,
  output logic              cpu_fault,
  output logic [1:0]        cpu_ce,
  output logic              grant,
  output logic              align_fault
);
  priv_lvl_e cur_lvl;

  priv_level_decode u_lvl (
    .exl (st_exl),
    .erl (st_erl),
    .ksu (st_ksu),
    .lvl (cur_lvl)
  );

  cop_gate #(.CE_W(2)) u_cop (
    .lvl    (cur_lvl),
    .usable (st_cu0),
    .req    (cp0_req),
    .fault  (cpu_fault),
    .ce     (cpu_ce)
  );

  span_check #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .SIZE_W      (SIZE_W)
  ) u_span (
    .valid (acc_valid),
    .addr  (acc_addr),
    .size  (acc_size),
    .fault (align_fault)
  );

  assign eff_level = cur_lvl;
  assign grant     = (cur_lvl >= need_level);

  always_comb begin
    if (st_exl || st_erl)
      p_forced_kernel_r1: assert (eff_level == LVL_KERNEL);
    if (need_level == LVL_USER)
      p_user_always_r3: assert (grant);
    if (cpu_fault)
      p_fault_cause_r4: assert (eff_level != LVL_KERNEL && !st_cu0 && cp0_req);
    if (cp0_req && (st_cu0 || eff_level == LVL_KERNEL))
      p_no_fault_r9: assert (!cpu_fault);
    if (!acc_valid)
      p_idle_quiet_r8: assert (!align_fault);
  end
endmodule

// File: tb/sim_priv_access_check.sv
module sim_priv_access_check;
  logic        clk = 1'b0;
  logic        st_exl = 0, st_erl = 0, st_cu0 = 0, cp0_req = 0, acc_valid = 0;
  logic [1:0]  st_ksu = 0, acc_size = 0, need_level = 0;
  logic [63:0] acc_addr = 0;
  logic [1:0]  eff_level, cpu_ce;
  logic        cpu_fault, grant, align_fault;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  priv_access_check u0 (
    .st_exl(st_exl), .st_erl(st_erl), .st_ksu(st_ksu), .st_cu0(st_cu0),
    .cp0_req(cp0_req), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .need_level(need_level), .eff_level(eff_level),
    .cpu_fault(cpu_fault), .cpu_ce(cpu_ce), .grant(grant),
    .align_fault(align_fault)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(bit exl, bit erl, bit [1:0] ksu);
    if (exl || erl) return 2;               // R1
    case (ksu)                              // R2
      2'b00: return 2;
      2'b01: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_span(logic [63:0] a, int sz, bit v);
    logic [64:0] f, l;
    if (!v) return 0;                       // R8
    f = {1'b0, a};
    l = f + 65'((1 << sz) - 1);             // R6 widths 1,2,4,8
    return (f / 16) != (l / 16);            // R7
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] bases [3];
    bases[0] = 64'h0;
    bases[1] = 64'h1234_5678_9ABC_DE00;
    bases[2] = 64'hFFFF_FFFF_FFFF_FFE0;

    // Idle state: all-zero status means kernel, nothing faults.
    @(negedge clk); #1;
    chk("R2 idle level", 8'(eff_level), 8'd2);
    chk("R3 idle grant", 8'(grant), 8'd1);
    chk("R8 idle align", 8'(align_fault), 8'd0);

    // Full sweep of status, request and required level.
    for (int i = 0; i < 256; i++) begin
      int lv;
      bit ef;
      @(negedge clk);
      {st_exl, st_erl, st_ksu, st_cu0, cp0_req, need_level} = 8'(i);
      #1;
      lv = exp_level(st_exl, st_erl, st_ksu);
      ef = cp0_req && lv != 2 && !st_cu0;
      chk((st_exl || st_erl) ? "R1 level" : "R2 level", 8'(eff_level), 8'(lv));
      chk("R3 grant", 8'(grant), 8'(lv >= int'(need_level)));
      chk(ef ? "R4 cop fault" : "R9 cop no fault", 8'(cpu_fault), 8'(ef));
      chk("R5 ce", 8'(cpu_ce), 8'd0);
    end

    // Alignment sweep: three bases, 32 offsets, four sizes, valid on/off.
    for (int b = 0; b < 3; b++)
      for (int off = 0; off < 32; off++)
        for (int sz = 0; sz < 4; sz++)
          for (int v = 0; v < 2; v++) begin
            bit e;
            @(negedge clk);
            acc_addr  = bases[b] + 64'(off);
            acc_size  = 2'(sz);
            acc_valid = v[0];
            #1;
            e = exp_span(acc_addr, sz, v[0]);
            chk(v[0] ? "R7 R6 span" : "R8 idle span", 8'(align_fault), 8'(e));
          end

    // Named corners from R7.
    @(negedge clk); acc_valid = 1; acc_addr = 64'h0E; acc_size = 2'd2; #1;
    chk("R7 0x0E word", 8'(align_fault), 8'd1);
    @(negedge clk); acc_addr = 64'h08; acc_size = 2'd3; #1;
    chk("R7 0x08 double", 8'(align_fault), 8'd0);
    @(negedge clk); acc_addr = 64'hFFFF_FFFF_FFFF_FFFF; acc_size = 2'd1; #1;
    chk("R7 top wrap", 8'(align_fault), 8'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule